// File: doc/BRIEF.md
# SDRAM Write Burst Column Sequencer

This block sits on the device side of an SDRAM-style command bus. It watches the command pins on every rising clock edge. When it sees a WRITE, it takes the bank, the starting column and the auto-precharge choice from the address pins. From that point it produces one write strobe per clock, with the bank and column, for a storage array that has two banks. The data word on the bus on the same edge as the command is the first beat. Every later edge carries the next beat.

The burst length is set by static configuration inputs. It is either a fixed length of 1, 2, 4 or 8 beats, or a full page. A fixed burst steps through its columns in sequential order inside its aligned block, then stops, and any data left on the bus is dropped. A full-page burst steps through the whole page, wraps from the last column back to column 0, and runs until a new WRITE replaces it.

A new WRITE can arrive on any clock and cuts short the burst in progress. Cutting short a burst that asked for auto precharge breaks the command rules, so the block flags it. A burst that completes with auto precharge set raises a one-cycle precharge request for its bank. All outputs are registered and appear one cycle after the edge that sampled the inputs.

Top module: `sdram_wr_burst_seq`

## Requirements
- R1: A WRITE is decoded on an edge where cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=0. One cycle after that edge, wr_en=1 and wr_bank, wr_col and wr_data show the bank, column and data sampled on that edge. If cke=0, no command is decoded.
- R2: With full_page=0, bl_sel selects 1, 2, 4 or 8 beats (codes 0, 1, 2, 3). Beat i of a burst that starts at column s goes to column (s with its low log2(len) bits replaced by (s+i) mod len). There is one beat per cycle.
- R3: After the last beat of a fixed burst, wr_en stays 0 while no new WRITE is decoded, whatever is on dq.
- R4: With full_page=1, the column goes up by one each beat. After the last column of the page it wraps to column 0, and the burst goes on until a new WRITE or reset.
- R5: A WRITE decoded while a burst is running ends that burst at once. The next output cycle carries the new bank, the new column and the data sampled with the new command. The new burst then continues.
- R6: trunc_err pulses, in the output cycle of the new command's first beat, when a WRITE cuts short a burst that had auto precharge enabled and still had beats left. A burst cut short this way raises no precharge request.
- R7: addr[10] sampled with the WRITE enables auto precharge. pre_req then pulses for one cycle together with the final beat of a completed fixed burst, with pre_bank equal to that burst's bank.
- R8: ba selects bank 0 or 1. The column comes from addr[9:0]. In the x8 configuration (the default), bit 9 is ignored and wr_col[9] is always 0, so a page holds 512 columns.
- R9: Deselect (cs_n=1), NOP and any command other than WRITE leave a running burst unchanged.
- R10: A synchronous active-high rst ends any burst. While rst is high and on the cycle after it falls, wr_en, pre_req and trunc_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bl_sel | input | 2 | Fixed burst length code: 0=1, 1=2, 2=4, 3=8 beats |
| full_page | input | 1 | 1 selects full-page bursts |
| cke | input | 1 | Clock enable; a command is decoded only when high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable pin, active low |
| ba | input | 1 | Bank select |
| addr | input | 12 | Address pins: column in [9:0], auto precharge in [10] |
| dq | input | 8 | Write data bus |
| wr_en | output | 1 | Array write strobe for this beat |
| wr_bank | output | 1 | Bank of this beat |
| wr_col | output | 10 | Column of this beat |
| wr_data | output | 8 | Data of this beat |
| pre_req | output | 1 | One-cycle precharge request |
| pre_bank | output | 1 | Bank to precharge |
| trunc_err | output | 1 | Pulse: an auto-precharge burst was cut short |

## Verification
The assertions check the following on every cycle. Each decoded WRITE yields a beat at its own column on the next cycle. A running burst never drops a beat unless a WRITE or reset intervenes. An idle sequencer never strobes. Precharge and error pulses appear only alongside a beat, and in the x8 configuration the top column bit stays clear. Some behaviour can only be shown by the bench scenarios with known stimulus. These are the exact column order inside each aligned block, the wrap from the page end to column 0, and the pairing of data with columns when a burst is cut short. They also cover where the precharge pulse lands and the fact that dq is dropped once a fixed burst ends.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  // Largest fixed burst length, in beats
  localparam int unsigned MAX_BURST = 8;
  localparam int unsigned LEFT_W    = $clog2(MAX_BURST);

  typedef enum logic [1:0] {
    LEN_1 = 2'd0,
    LEN_2 = 2'd1,
    LEN_4 = 2'd2,
    LEN_8 = 2'd3
  } burst_len_e;

  // Beats that follow the second beat of a fixed burst
  function automatic logic [LEFT_W-1:0] beats_after_second(input logic [1:0] code);
    return LEFT_W'((1 << code) - 2);
  endfunction

endpackage

// File: rtl/wr_cmd_decode.sv
module wr_cmd_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned AP_BIT = 10,
  parameter bit          X8     = 1'b1
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_wr,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic              ap
);

  localparam int unsigned PAGE_W = X8 ? COL_W - 1 : COL_W;
  localparam logic [COL_W-1:0] PAGE_MASK = COL_W'((1 << PAGE_W) - 1);

  always_comb begin
    is_wr = cke & ~cs_n & ras_n & ~cas_n & ~we_n;
    col   = addr[COL_W-1:0] & PAGE_MASK;
    bank  = ba;
    ap    = addr[AP_BIT];
  end

endmodule

// File: rtl/burst_col_step.sv
module burst_col_step #(
  parameter int unsigned COL_W = 10,
  parameter bit          X8    = 1'b1
) (
  input  logic [COL_W-1:0] cur,
  input  logic [1:0]       bl_sel,
  input  logic             full_page,
  output logic [COL_W-1:0] nxt
);

  localparam int unsigned PAGE_W = X8 ? COL_W - 1 : COL_W;
  localparam logic [COL_W-1:0] PAGE_MASK = COL_W'((1 << PAGE_W) - 1);

  logic [COL_W-1:0] blk_mask;
  logic [COL_W-1:0] inc;

  always_comb begin
    blk_mask = (COL_W'(1) << bl_sel) - COL_W'(1);
    inc      = cur + COL_W'(1);
    if (full_page) begin
      nxt = inc & PAGE_MASK;
    end else begin
      nxt = (cur & ~blk_mask) | (inc & blk_mask);
    end
  end

endmodule

// File: rtl/burst_seq_core.sv
module burst_seq_core
  import sdram_wr_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 1,
  parameter bit          X8     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bl_sel,
  input  logic              full_page,
  input  logic              is_wr,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  output logic              wr_en_q,
  output logic [COL_W-1:0]  wr_col_q,
  output logic [BANK_W-1:0] wr_bank_q,
  output logic              pre_q,
  output logic [BANK_W-1:0] pre_bank_q,
  output logic              err_q
);

  logic              run;
  logic [COL_W-1:0]  nxt_col;
  logic [LEFT_W-1:0] left;
  logic              ap_q;
  logic [BANK_W-1:0] bank_q;

  logic [COL_W-1:0]  cmd_step;
  logic [COL_W-1:0]  run_step;
  logic              single;

  assign single = ~full_page & (bl_sel == LEN_1);

  burst_col_step #(.COL_W(COL_W), .X8(X8)) u_step_cmd (
    .cur(cmd_col), .bl_sel(bl_sel), .full_page(full_page), .nxt(cmd_step)
  );

  burst_col_step #(.COL_W(COL_W), .X8(X8)) u_step_run (
    .cur(nxt_col), .bl_sel(bl_sel), .full_page(full_page), .nxt(run_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      nxt_col    <= '0;
      left       <= '0;
      ap_q       <= 1'b0;
      bank_q     <= '0;
      wr_en_q    <= 1'b0;
      wr_col_q   <= '0;
      wr_bank_q  <= '0;
      pre_q      <= 1'b0;
      pre_bank_q <= '0;
      err_q      <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      pre_q   <= 1'b0;
      err_q   <= 1'b0;
      if (is_wr) begin
        wr_en_q   <= 1'b1;
        wr_col_q  <= cmd_col;
        wr_bank_q <= cmd_bank;
        err_q     <= run & ap_q;
        bank_q    <= cmd_bank;
        ap_q      <= cmd_ap;
        nxt_col   <= cmd_step;
        if (single) begin
          run        <= 1'b0;
          pre_q      <= cmd_ap;
          pre_bank_q <= cmd_bank;
        end else begin
          run  <= 1'b1;
          left <= beats_after_second(bl_sel);
        end
      end else if (run) begin
        wr_en_q   <= 1'b1;
        wr_col_q  <= nxt_col;
        wr_bank_q <= bank_q;
        nxt_col   <= run_step;
        if (!full_page) begin
          if (left == '0) begin
            run        <= 1'b0;
            pre_q      <= ap_q;
            pre_bank_q <= bank_q;
          end else begin
            left <= left - LEFT_W'(1);
          end
        end
      end
    end
  end

  // R1
  cmd_beat_chk: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> (wr_en_q && wr_col_q == $past(cmd_col) && wr_bank_q == $past(cmd_bank)));

  // R9
  burst_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !is_wr) |=> wr_en_q);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !is_wr) |=> !wr_en_q);

  // R7
  pre_last_chk: assert property (@(posedge clk) disable iff (rst)
    pre_q |-> (wr_en_q && pre_bank_q == wr_bank_q));

  // R6
  err_with_beat_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (wr_en_q && !pre_q));

endmodule

// File: rtl/sdram_wr_burst_seq.sv
module sdram_wr_burst_seq #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned BANK_W = 1,
  parameter int unsigned DQ_W   = 8,
  parameter int unsigned AP_BIT = 10,
  parameter bit          X8     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bl_sel,
  input  logic              full_page,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic [DQ_W-1:0]   wr_data,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank,
  output logic              trunc_err
);

  logic              is_wr;
  logic [COL_W-1:0]  cmd_col;
  logic [BANK_W-1:0] cmd_bank;
  logic              cmd_ap;
  logic [DQ_W-1:0]   data_q;

  wr_cmd_decode #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .AP_BIT(AP_BIT), .X8(X8)
  ) u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr),
    .is_wr(is_wr), .col(cmd_col), .bank(cmd_bank), .ap(cmd_ap)
  );

  burst_seq_core #(
    .COL_W(COL_W), .BANK_W(BANK_W), .X8(X8)
  ) u_core (
    .clk(clk), .rst(rst), .bl_sel(bl_sel), .full_page(full_page),
    .is_wr(is_wr), .cmd_col(cmd_col), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .wr_en_q(wr_en), .wr_col_q(wr_col), .wr_bank_q(wr_bank),
    .pre_q(pre_req), .pre_bank_q(pre_bank), .err_q(trunc_err)
  );

  // Data capture stage: one register, aligned with the column pipeline
  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= dq;
  end
  assign wr_data = data_q;

  generate
    if (X8) begin : g_x8_chk
      // R8
      x8_col_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !wr_col[COL_W-1]);
    end
  endgenerate

endmodule

// File: tb/tb_sdram_wr_burst_seq.sv
module tb_sdram_wr_burst_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bl_sel;
  logic        full_page;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [0:0]  ba;
  logic [11:0] addr;
  logic [7:0]  dq;
  logic        wr_en;
  logic [0:0]  wr_bank;
  logic [9:0]  wr_col;
  logic [7:0]  wr_data;
  logic        pre_req;
  logic [0:0]  pre_bank;
  logic        trunc_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_wr_burst_seq dut (
    .clk(clk), .rst(rst), .bl_sel(bl_sel), .full_page(full_page),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dq(dq),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
    .pre_req(pre_req), .pre_bank(pre_bank), .trunc_err(trunc_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_nop(input logic [7:0] d);
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 1'b0; addr = '0; dq = d;
  endtask

  task automatic drive_wr(input logic b, input logic [9:0] c, input logic ap,
                          input logic [7:0] d);
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b0;
    ba = b; addr = {1'b0, ap, c}; dq = d;
  endtask

  task automatic chk_beat(input string tag, input logic b, input logic [9:0] c,
                          input logic [7:0] d);
    chk({tag, " wr_en"}, wr_en, 1);
    chk({tag, " bank"}, wr_bank, b);
    chk({tag, " col"}, wr_col, c);
    chk({tag, " data"}, wr_data, d);
  endtask

  function automatic logic [9:0] exp_col(input logic [9:0] s, input int n, input int i);
    int base = int'(s) - (int'(s) % n);
    return 10'((base + ((int'(s) % n) + i) % n) & 511);
  endfunction

  task automatic t_reset();
    rst = 1'b1; full_page = 1'b0; bl_sel = 2'd1;
    drive_wr(1'b0, 10'd3, 1'b0, 8'h11);
    repeat (3) @(negedge clk);
    chk("R10 reset wr_en", wr_en, 0);
    chk("R10 reset pre_req", pre_req, 0);
    chk("R10 reset trunc_err", trunc_err, 0);
    drive_nop(8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset wr_en", wr_en, 0);
  endtask

  task automatic t_fixed(input string tag, input logic [1:0] code, input logic b,
                         input logic [9:0] s, input logic [7:0] d0);
    int n = 1 << code;
    bl_sel = code; full_page = 1'b0;
    drive_wr(b, s, 1'b0, d0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_beat({tag, " R2 beat"}, b, exp_col(s & 10'h1FF, n, i), d0 + 8'(i));
      chk({tag, " R7 no pre"}, pre_req, 0);
      drive_nop(d0 + 8'(i + 1));
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk({tag, " R3 idle"}, wr_en, 0);
      drive_nop(8'hEE);
    end
  endtask

  task automatic t_cke_low();
    drive_wr(1'b1, 10'd7, 1'b0, 8'h42);
    cke = 1'b0;
    @(negedge clk);
    drive_nop(8'h00);
    @(negedge clk);
    chk("R1 cke low no beat", wr_en, 0);
  endtask

  task automatic t_full_page();
    logic [9:0] c;
    full_page = 1'b1; bl_sel = 2'd3;
    drive_wr(1'b0, 10'h1FE, 1'b0, 8'h50);
    c = 10'h1FE;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_beat("R4 page beat", 1'b0, c, 8'h50 + 8'(i));
      c = (c + 10'd1) & 10'h1FF;
      drive_nop(8'h51 + 8'(i));
      if (i == 2) cs_n = 1'b1;
      if (i == 3) begin cas_n = 1'b0; we_n = 1'b1; end
    end
    drive_wr(1'b1, 10'h020, 1'b0, 8'hA5);
    @(negedge clk);
    chk_beat("R5 page truncate", 1'b1, 10'h020, 8'hA5);
    chk("R6 no err non-ap", trunc_err, 0);
    drive_nop(8'hA6);
    @(negedge clk);
    chk_beat("R5 new page burst", 1'b1, 10'h021, 8'hA6);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid-burst reset", wr_en, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 stays idle", wr_en, 0);
    full_page = 1'b0;
  endtask

  task automatic t_ap_complete();
    bl_sel = 2'd1; full_page = 1'b0;
    drive_wr(1'b1, 10'h010, 1'b1, 8'h70);
    @(negedge clk);
    chk_beat("R7 ap beat0", 1'b1, 10'h010, 8'h70);
    chk("R7 no pre early", pre_req, 0);
    drive_nop(8'h71);
    @(negedge clk);
    chk_beat("R7 ap beat1", 1'b1, 10'h011, 8'h71);
    chk("R7 pre_req", pre_req, 1);
    chk("R7 pre_bank", pre_bank, 1);
    drive_nop(8'h72);
    @(negedge clk);
    chk("R7 pre one cycle", pre_req, 0);
    bl_sel = 2'd0;
    drive_wr(1'b0, 10'h033, 1'b1, 8'h80);
    @(negedge clk);
    chk_beat("R7 bl1 ap beat", 1'b0, 10'h033, 8'h80);
    chk("R7 bl1 pre_req", pre_req, 1);
    chk("R7 bl1 pre_bank", pre_bank, 0);
    drive_nop(8'h81);
    @(negedge clk);
    chk("R3 bl1 done", wr_en, 0);
  endtask

  task automatic t_ap_truncate();
    bl_sel = 2'd2; full_page = 1'b0;
    drive_wr(1'b0, 10'h040, 1'b1, 8'h90);
    @(negedge clk);
    chk_beat("R2 ap4 beat0", 1'b0, 10'h040, 8'h90);
    drive_wr(1'b1, 10'h080, 1'b0, 8'h91);
    @(negedge clk);
    chk_beat("R5 trunc beat", 1'b1, 10'h080, 8'h91);
    chk("R6 trunc_err", trunc_err, 1);
    chk("R6 no pre on trunc", pre_req, 0);
    for (int i = 1; i < 4; i++) begin
      drive_nop(8'h91 + 8'(i));
      @(negedge clk);
      chk_beat("R5 new burst", 1'b1, 10'h080 + 10'(i), 8'h91 + 8'(i));
      chk("R6 err one cycle", trunc_err, 0);
      chk("R6 old ap gone", pre_req, 0);
    end
    drive_nop(8'h00);
    @(negedge clk);
    chk("R3 after trunc burst", wr_en, 0);
  endtask

  task automatic t_plain_truncate();
    bl_sel = 2'd3; full_page = 1'b0;
    drive_wr(1'b0, 10'h000, 1'b0, 8'hC0);
    @(negedge clk);
    drive_nop(8'hC1);
    @(negedge clk);
    chk_beat("R2 bl8 beat1", 1'b0, 10'h001, 8'hC1);
    drive_wr(1'b0, 10'h105, 1'b0, 8'hD0);
    @(negedge clk);
    chk_beat("R5 bl8 trunc", 1'b0, 10'h105, 8'hD0);
    chk("R6 no err plain", trunc_err, 0);
    drive_nop(8'hD1);
    @(negedge clk);
    chk_beat("R2 bl8 new order", 1'b0, 10'h106, 8'hD1);
    drive_nop(8'h00);
    repeat (7) @(negedge clk);
    chk("R3 bl8 finished", wr_en, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive_nop(8'h00);
    rst = 1'b1; bl_sel = 2'd0; full_page = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed("len2", 2'd1, 1'b0, 10'h004, 8'h10);
    t_fixed("len4", 2'd2, 1'b1, 10'h006, 8'h20);
    t_fixed("len8", 2'd3, 1'b0, 10'h0F3, 8'h30);
    t_fixed("R8 len1 x8", 2'd0, 1'b1, 10'h3FC, 8'h40);
    t_cke_low();
    t_full_page();
    t_ap_complete();
    t_ap_truncate();
    t_plain_truncate();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule